// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block captures hardware error reports into a small array of error banks. Each bank keeps four 64-bit words: an enable mask, a status word, a faulting address and a free-form detail word. Beside the banks sit three global registers: a capability word (bank count and a flag saying a global enable mask exists), the global enable mask itself, and a global status word whose bit 2 marks an exception that is still being handled.

An error source presents an injection request carrying a bank index, a status word, a global status value, an address, a detail word and an unconditional flag. In a single clock the block screens the request, then does one of four things. It can reject it with a code. It can drop it silently. It can escalate to a shutdown request. Or it can log it, with the class-dependent overwrite rules and overflow marking described below. An accepted uncorrected error also raises an exception request. A simple load port presets any register, and a registered read port shows one bank at a time.

Top module: `mc_err_logger`

## Requirements
- R1: After a synchronous reset every register and bank word is zero and the exception, shutdown and reject outputs are low.
- R2: A request made while the capability word is zero is rejected with code 1.
- R3: A request whose bank index is not below the count in capability bits 7:0 (or not below the number of built banks) is rejected with code 2; the highest counted bank is accepted.
- R4: A request whose status bit 63 (valid) is clear is rejected with code 3 and changes no bank.
- R5: When global status bit 2 (in progress) is set, a request whose status bit 55 (action required) is clear and whose unconditional flag is low is dropped with no output and no state change; with the flag high it is processed normally.
- R6: An uncorrected request (status bit 61 set) is rejected with code 4 when capability bit 8 is set and the global enable mask is not all ones; with capability bit 8 clear the mask is not consulted.
- R7: An uncorrected request is rejected with code 5 when the addressed bank's enable mask is not all ones.
- R8: An uncorrected request that passes R6 and R7 while global status bit 2 is set or the machine-check enable input is low raises a shutdown pulse and leaves the bank unchanged.
- R9: An accepted uncorrected request writes the bank's status, address and detail words and the global status word, sets status bit 62 (overflow) if the bank was already valid, and raises an exception pulse.
- R10: A corrected request to a bank that is empty or holds a corrected entry overwrites status, address and detail, setting bit 62 when the old entry was valid; no exception pulse results.
- R11: A corrected request to a bank holding a valid uncorrected entry only sets bit 62 of that entry; address and detail stay as they were.
- R12: Each outcome is a one-cycle pulse in the cycle after the request, and at most one of exception, shutdown and reject is high.
- R13: The load port selects its target with codes 0 capability, 1 global enable mask, 2 global status, 3 bank enable mask, 4 bank status, 5 bank address, 6 bank detail; an injection in the same cycle takes precedence over a load to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mce_en | input | 1 | Machine-check enable; low forces uncorrected errors to shutdown |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Load target code (R13) |
| ld_bank | input | IDX_W | Bank addressed by a bank load |
| ld_data | input | 64 | Load value |
| req_valid | input | 1 | Injection request strobe |
| req_bank | input | 8 | Requested bank index |
| req_status | input | 64 | Status word of the report |
| req_gstat | input | 64 | Global status to install with an uncorrected error |
| req_addr | input | ADDR_W | Faulting address |
| req_misc | input | 64 | Detail word |
| req_uncond | input | 1 | Process even while an exception is in progress |
| rd_bank | input | IDX_W | Bank shown on the read port |
| exc_o | output | 1 | Exception request pulse |
| shutdown_o | output | 1 | Shutdown request pulse |
| rej_o | output | 1 | Reject pulse |
| rej_code_o | output | 3 | Reject reason, valid with rej_o |
| gstat_o | output | 64 | Global status word |
| rd_ctl_o | output | 64 | Enable mask of the read bank (registered) |
| rd_status_o | output | 64 | Status of the read bank (registered) |
| rd_addr_o | output | ADDR_W | Address of the read bank (registered) |
| rd_misc_o | output | 64 | Detail word of the read bank (registered) |

## Verification
The properties assume that inputs settle between clock edges and that the capability word and enable masks are stable across the edge where a request is screened, since the verdict uses their current register values. The overflow and global status properties rely on the rule that an injection wins over a load to the same word. The bench drives every input on the falling edge, never issues a load and an injection in the same cycle, and keeps bank indices within 8 bits.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

  localparam int STAT_W        = 64;
  localparam int VAL_BIT       = 63;
  localparam int OVF_BIT       = 62;
  localparam int UC_BIT        = 61;
  localparam int AR_BIT        = 55;
  localparam int GS_INPROG_BIT = 2;
  localparam int CAP_CNT_W     = 8;
  localparam int CAP_GCTL_BIT  = 8;

  typedef enum logic [2:0] {
    REJ_NONE    = 3'd0,
    REJ_NOSUP   = 3'd1,
    REJ_BADBANK = 3'd2,
    REJ_BADSTAT = 3'd3,
    REJ_GCTL    = 3'd4,
    REJ_BANKCTL = 3'd5
  } rej_e;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_DROP,
    ACT_REJECT,
    ACT_SHUTDOWN,
    ACT_LOG_UC,
    ACT_LOG_CE,
    ACT_OVF_ONLY
  } act_e;

  typedef enum logic [2:0] {
    LD_CAP   = 3'd0,
    LD_GCTL  = 3'd1,
    LD_GSTAT = 3'd2,
    LD_BCTL  = 3'd3,
    LD_BSTAT = 3'd4,
    LD_BADDR = 3'd5,
    LD_BMISC = 3'd6,
    LD_NONE  = 3'd7
  } ld_e;

  typedef struct packed {
    act_e              act;
    rej_e              rej;
    logic [STAT_W-1:0] new_stat;
  } verdict_t;

endpackage

// File: rtl/mcl_ctrl_regs.sv
module mcl_ctrl_regs
  import mcl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [2:0]        ld_sel,
  input  logic [63:0]       ld_data,
  input  logic              gs_wr,
  input  logic [63:0]       gs_wdata,
  output logic [63:0]       cap_q,
  output logic [63:0]       gctl_q,
  output logic [63:0]       gstat_q
);

  ld_e sel;
  assign sel = ld_e'(ld_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      gctl_q  <= '0;
      gstat_q <= '0;
    end else begin
      if (ld_en && sel == LD_CAP)  cap_q  <= ld_data;
      if (ld_en && sel == LD_GCTL) gctl_q <= ld_data;
      if (gs_wr)                         gstat_q <= gs_wdata;
      else if (ld_en && sel == LD_GSTAT) gstat_q <= ld_data;
    end
  end

  // R9: an accepted uncorrected report installs its global status
  p_gstat_follow_r9: assert property (@(posedge clk) disable iff (rst)
    gs_wr |=> gstat_q == $past(gs_wdata));

endmodule

// File: rtl/mcl_screen.sv
module mcl_screen
  import mcl_pkg::*;
#(
  parameter int NBANKS = 8
) (
  input  logic              req_valid,
  input  logic [7:0]        req_bank,
  input  logic [STAT_W-1:0] req_status,
  input  logic              req_uncond,
  input  logic              mce_en,
  input  logic [63:0]       cap_q,
  input  logic [63:0]       gctl_q,
  input  logic              in_prog,
  input  logic [63:0]       cur_ctl,
  input  logic              cur_val,
  input  logic              cur_uc,
  output verdict_t          verdict
);

  localparam logic [8:0] NB9 = 9'(NBANKS);

  logic in_range;
  logic cap_none;

  assign cap_none = ~|cap_q;
  assign in_range = (req_bank < cap_q[CAP_CNT_W-1:0]) && ({1'b0, req_bank} < NB9);

  always_comb begin
    verdict.act      = ACT_IDLE;
    verdict.rej      = REJ_NONE;
    verdict.new_stat = req_status;
    verdict.new_stat[OVF_BIT] = req_status[OVF_BIT] | cur_val;
    if (req_valid) begin
      if (cap_none) begin
        verdict.act = ACT_REJECT;
        verdict.rej = REJ_NOSUP;
      end else if (!in_range) begin
        verdict.act = ACT_REJECT;
        verdict.rej = REJ_BADBANK;
      end else if (!req_status[VAL_BIT]) begin
        verdict.act = ACT_REJECT;
        verdict.rej = REJ_BADSTAT;
      end else if (!req_uncond && !req_status[AR_BIT] && in_prog) begin
        verdict.act = ACT_DROP;
      end else if (req_status[UC_BIT]) begin
        if (cap_q[CAP_GCTL_BIT] && !(&gctl_q)) begin
          verdict.act = ACT_REJECT;
          verdict.rej = REJ_GCTL;
        end else if (!(&cur_ctl)) begin
          verdict.act = ACT_REJECT;
          verdict.rej = REJ_BANKCTL;
        end else if (in_prog || !mce_en) begin
          verdict.act = ACT_SHUTDOWN;
        end else begin
          verdict.act = ACT_LOG_UC;
        end
      end else if (!cur_val || !cur_uc) begin
        verdict.act = ACT_LOG_CE;
      end else begin
        verdict.act = ACT_OVF_ONLY;
      end
    end
  end

endmodule

// File: rtl/mcl_bank_file.sv
module mcl_bank_file
  import mcl_pkg::*;
#(
  parameter int NBANKS = 8,
  parameter int ADDR_W = 64,
  localparam int IDX_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [2:0]        ld_sel,
  input  logic [IDX_W-1:0]  ld_bank,
  input  logic [63:0]       ld_data,
  input  logic              wr_log,
  input  logic              wr_ovf,
  input  logic [7:0]        wr_bank,
  input  logic [STAT_W-1:0] wr_stat,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [63:0]       wr_misc,
  input  logic [7:0]        look_bank,
  output logic [63:0]       look_ctl,
  output logic [STAT_W-1:0] look_stat,
  input  logic [IDX_W-1:0]  rd_bank,
  output logic [63:0]       rd_ctl,
  output logic [STAT_W-1:0] rd_stat,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [63:0]       rd_misc
);

  logic [63:0]       ctl_q  [NBANKS];
  logic [STAT_W-1:0] stat_q [NBANKS];
  logic [ADDR_W-1:0] addr_q [NBANKS];
  logic [63:0]       misc_q [NBANKS];

  ld_e sel;
  assign sel = ld_e'(ld_sel);

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    logic wr_hit;
    logic ld_hit;
    assign wr_hit = (wr_bank == 8'(g));
    assign ld_hit = ld_en && (ld_bank == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q[g]  <= '0;
        stat_q[g] <= '0;
        addr_q[g] <= '0;
        misc_q[g] <= '0;
      end else begin
        if (ld_hit && sel == LD_BCTL) ctl_q[g] <= ld_data;
        if (wr_hit && wr_log) begin
          stat_q[g] <= wr_stat;
          addr_q[g] <= wr_addr;
          misc_q[g] <= wr_misc;
        end else if (wr_hit && wr_ovf) begin
          stat_q[g][OVF_BIT] <= 1'b1;
        end else if (ld_hit) begin
          if (sel == LD_BSTAT) stat_q[g] <= ld_data;
          if (sel == LD_BADDR) addr_q[g] <= ld_data[ADDR_W-1:0];
          if (sel == LD_BMISC) misc_q[g] <= ld_data;
        end
      end
    end

    // R11: a corrected report over a live uncorrected entry only marks overflow
    p_ovf_only_r11: assert property (@(posedge clk) disable iff (rst)
      (wr_hit && wr_ovf) |=> stat_q[g][OVF_BIT] && stat_q[g][UC_BIT] &&
                             stat_q[g][VAL_BIT] && $stable(addr_q[g]));

    // R10: logging over a valid entry leaves the overflow mark
    p_ovf_mark_r10: assert property (@(posedge clk) disable iff (rst)
      (wr_hit && wr_log && stat_q[g][VAL_BIT]) |=> stat_q[g][OVF_BIT]);
  end

  always_comb begin
    look_ctl  = '0;
    look_stat = '0;
    for (int i = 0; i < NBANKS; i++) begin
      if (look_bank == 8'(i)) begin
        look_ctl  = ctl_q[i];
        look_stat = stat_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ctl  <= '0;
      rd_stat <= '0;
      rd_addr <= '0;
      rd_misc <= '0;
    end else if (int'(rd_bank) < NBANKS) begin
      rd_ctl  <= ctl_q[rd_bank];
      rd_stat <= stat_q[rd_bank];
      rd_addr <= addr_q[rd_bank];
      rd_misc <= misc_q[rd_bank];
    end else begin
      rd_ctl  <= '0;
      rd_stat <= '0;
      rd_addr <= '0;
      rd_misc <= '0;
    end
  end

endmodule

// File: rtl/mc_err_logger.sv
module mc_err_logger
  import mcl_pkg::*;
#(
  parameter int NBANKS = 8,
  parameter int ADDR_W = 64,
  localparam int IDX_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mce_en,
  input  logic              ld_en,
  input  logic [2:0]        ld_sel,
  input  logic [IDX_W-1:0]  ld_bank,
  input  logic [63:0]       ld_data,
  input  logic              req_valid,
  input  logic [7:0]        req_bank,
  input  logic [63:0]       req_status,
  input  logic [63:0]       req_gstat,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_misc,
  input  logic              req_uncond,
  input  logic [IDX_W-1:0]  rd_bank,
  output logic              exc_o,
  output logic              shutdown_o,
  output logic              rej_o,
  output logic [2:0]        rej_code_o,
  output logic [63:0]       gstat_o,
  output logic [63:0]       rd_ctl_o,
  output logic [63:0]       rd_status_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [63:0]       rd_misc_o
);

  logic [63:0]       cap_q;
  logic [63:0]       gctl_q;
  logic [63:0]       gstat_q;
  logic [63:0]       look_ctl;
  logic [STAT_W-1:0] look_stat;
  verdict_t          verdict;
  logic              log_uc;
  logic              log_any;
  logic              ovf_only;

  assign log_uc   = (verdict.act == ACT_LOG_UC);
  assign log_any  = log_uc || (verdict.act == ACT_LOG_CE);
  assign ovf_only = (verdict.act == ACT_OVF_ONLY);

  mcl_ctrl_regs u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_en),
    .ld_sel   (ld_sel),
    .ld_data  (ld_data),
    .gs_wr    (log_uc),
    .gs_wdata (req_gstat),
    .cap_q    (cap_q),
    .gctl_q   (gctl_q),
    .gstat_q  (gstat_q)
  );

  mcl_screen #(.NBANKS(NBANKS)) u_screen (
    .req_valid  (req_valid),
    .req_bank   (req_bank),
    .req_status (req_status),
    .req_uncond (req_uncond),
    .mce_en     (mce_en),
    .cap_q      (cap_q),
    .gctl_q     (gctl_q),
    .in_prog    (gstat_q[GS_INPROG_BIT]),
    .cur_ctl    (look_ctl),
    .cur_val    (look_stat[VAL_BIT]),
    .cur_uc     (look_stat[UC_BIT]),
    .verdict    (verdict)
  );

  mcl_bank_file #(.NBANKS(NBANKS), .ADDR_W(ADDR_W)) u_banks (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (ld_en),
    .ld_sel    (ld_sel),
    .ld_bank   (ld_bank),
    .ld_data   (ld_data),
    .wr_log    (log_any),
    .wr_ovf    (ovf_only),
    .wr_bank   (req_bank),
    .wr_stat   (verdict.new_stat),
    .wr_addr   (req_addr),
    .wr_misc   (req_misc),
    .look_bank (req_bank),
    .look_ctl  (look_ctl),
    .look_stat (look_stat),
    .rd_bank   (rd_bank),
    .rd_ctl    (rd_ctl_o),
    .rd_stat   (rd_status_o),
    .rd_addr   (rd_addr_o),
    .rd_misc   (rd_misc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_o      <= 1'b0;
      shutdown_o <= 1'b0;
      rej_o      <= 1'b0;
      rej_code_o <= 3'd0;
    end else begin
      exc_o      <= log_uc;
      shutdown_o <= (verdict.act == ACT_SHUTDOWN);
      rej_o      <= (verdict.act == ACT_REJECT);
      rej_code_o <= verdict.rej;
    end
  end

  assign gstat_o = gstat_q;

  // R12: outcomes are exclusive and come only from a request one cycle earlier
  p_one_outcome_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exc_o, shutdown_o, rej_o}));

  p_pulse_source_r12: assert property (@(posedge clk) disable iff (rst)
    (exc_o || shutdown_o || rej_o) |-> $past(req_valid));

  // R3: out-of-range bank index is refused
  p_badbank_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (|cap_q) && (req_bank >= cap_q[CAP_CNT_W-1:0]))
      |=> rej_o && rej_code_o == 3'd2);

  // R4: a report without the valid bit is refused
  p_nostat_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (|cap_q) && (req_bank < cap_q[CAP_CNT_W-1:0]) &&
     ({1'b0, req_bank} < 9'(NBANKS)) && !req_status[VAL_BIT])
      |=> rej_o && rej_code_o == 3'd3);

  // R8: shutdown only for an uncorrected report
  p_shut_uc_r8: assert property (@(posedge clk) disable iff (rst)
    shutdown_o |-> $past(req_status[UC_BIT]));

  // R9: exception only for a valid uncorrected report
  p_exc_uc_r9: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> $past(req_status[UC_BIT]) && $past(req_status[VAL_BIT]));

endmodule

// File: tb/tb_mc_err_logger.sv
`timescale 1ns/1ps
module tb_mc_err_logger;

  localparam int NBANKS = 8;
  localparam int ADDR_W = 64;
  localparam int IDX_W  = 3;

  localparam logic [63:0] VAL  = 64'h1 << 63;
  localparam logic [63:0] OVF  = 64'h1 << 62;
  localparam logic [63:0] UC   = 64'h1 << 61;
  localparam logic [63:0] AR   = 64'h1 << 55;
  localparam logic [63:0] ONES = '1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mce_en = 1'b0;
  logic              ld_en = 1'b0;
  logic [2:0]        ld_sel = 3'd7;
  logic [IDX_W-1:0]  ld_bank = '0;
  logic [63:0]       ld_data = '0;
  logic              req_valid = 1'b0;
  logic [7:0]        req_bank = '0;
  logic [63:0]       req_status = '0;
  logic [63:0]       req_gstat = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0]       req_misc = '0;
  logic              req_uncond = 1'b0;
  logic [IDX_W-1:0]  rd_bank = '0;
  logic              exc_o, shutdown_o, rej_o;
  logic [2:0]        rej_code_o;
  logic [63:0]       gstat_o, rd_ctl_o, rd_status_o, rd_misc_o;
  logic [ADDR_W-1:0] rd_addr_o;

  int n_checks = 0;
  int n_err    = 0;

  logic       o_exc, o_sh, o_rej;
  logic [2:0] o_code;

  always #2 clk = ~clk;

  mc_err_logger #(.NBANKS(NBANKS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .mce_en(mce_en),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_bank(ld_bank), .ld_data(ld_data),
    .req_valid(req_valid), .req_bank(req_bank), .req_status(req_status),
    .req_gstat(req_gstat), .req_addr(req_addr), .req_misc(req_misc),
    .req_uncond(req_uncond), .rd_bank(rd_bank),
    .exc_o(exc_o), .shutdown_o(shutdown_o), .rej_o(rej_o), .rej_code_o(rej_code_o),
    .gstat_o(gstat_o), .rd_ctl_o(rd_ctl_o), .rd_status_o(rd_status_o),
    .rd_addr_o(rd_addr_o), .rd_misc_o(rd_misc_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] s, input logic [IDX_W-1:0] b, input logic [63:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = s; ld_bank = b; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0; ld_sel = 3'd7;
  endtask

  task automatic inject(input logic [7:0] b, input logic [63:0] st, input logic [63:0] gs,
                        input logic [63:0] ad, input logic [63:0] mi, input logic unc);
    @(negedge clk);
    req_valid = 1'b1; req_bank = b; req_status = st; req_gstat = gs;
    req_addr = ad; req_misc = mi; req_uncond = unc;
    @(negedge clk);
    req_valid = 1'b0;
    o_exc = exc_o; o_sh = shutdown_o; o_rej = rej_o; o_code = rej_code_o;
    @(negedge clk);
    chk("R12 pulse ends after one cycle", {61'd0, exc_o, shutdown_o, rej_o}, 64'd0);
  endtask

  task automatic outcome(input string tag, input logic e, input logic s, input logic r,
                         input logic [2:0] c);
    chk(tag, {57'd0, o_exc, o_sh, o_rej, 1'b0, o_code}, {57'd0, e, s, r, 1'b0, c});
  endtask

  task automatic rd(input logic [IDX_W-1:0] b);
    @(negedge clk);
    rd_bank = b;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 outputs after reset", {61'd0, exc_o, shutdown_o, rej_o}, 64'd0);
    chk("R1 global status after reset", gstat_o, 64'd0);
    rd(0);
    chk("R1 bank status after reset", rd_status_o, 64'd0);
  endtask

  task automatic t_nocap;
    inject(8'd0, VAL | 64'h1, 64'd0, 64'h10, 64'h20, 1'b0);
    outcome("R2 zero capability rejects", 1'b0, 1'b0, 1'b1, 3'd1);
  endtask

  task automatic t_setup;
    load(3'd0, '0, 64'h104);
    load(3'd1, '0, ONES);
    for (int i = 0; i < 4; i++) load(3'd3, IDX_W'(i), ONES);
    mce_en = 1'b1;
    rd(3);
    chk("R13 bank enable mask loaded", rd_ctl_o, ONES);
  endtask

  task automatic t_badbank;
    inject(8'd4, VAL | 64'h1, 64'd0, 64'h0, 64'h0, 1'b0);
    outcome("R3 bank at count rejected", 1'b0, 1'b0, 1'b1, 3'd2);
    inject(8'd200, VAL | 64'h1, 64'd0, 64'h0, 64'h0, 1'b0);
    outcome("R3 far bank rejected", 1'b0, 1'b0, 1'b1, 3'd2);
    inject(8'd3, VAL | 64'h13, 64'd0, 64'h300, 64'h301, 1'b0);
    outcome("R3 last counted bank accepted", 1'b0, 1'b0, 1'b0, 3'd0);
    rd(3);
    chk("R3 last bank logged", rd_status_o, VAL | 64'h13);
  endtask

  task automatic t_invalid;
    inject(8'd0, 64'h55, 64'd0, 64'h1, 64'h2, 1'b0);
    outcome("R4 missing valid bit rejected", 1'b0, 1'b0, 1'b1, 3'd3);
    rd(0);
    chk("R4 bank untouched", rd_status_o, 64'd0);
  endtask

  task automatic t_ce;
    inject(8'd0, VAL | 64'h11, 64'd0, 64'hA0, 64'hB0, 1'b0);
    outcome("R10 corrected into empty bank", 1'b0, 1'b0, 1'b0, 3'd0);
    rd(0);
    chk("R10 status written", rd_status_o, VAL | 64'h11);
    chk("R10 address written", rd_addr_o, 64'hA0);
    inject(8'd0, VAL | 64'h12, 64'd0, 64'hA1, 64'hB1, 1'b0);
    rd(0);
    chk("R10 corrected over corrected sets overflow", rd_status_o, VAL | OVF | 64'h12);
    chk("R10 detail replaced", rd_misc_o, 64'hB1);
  endtask

  task automatic t_uc_over_ce;
    inject(8'd0, VAL | UC | 64'h22, 64'h5, 64'hC0, 64'hD0, 1'b0);
    outcome("R9 uncorrected raises exception", 1'b1, 1'b0, 1'b0, 3'd0);
    rd(0);
    chk("R9 status with overflow", rd_status_o, VAL | UC | OVF | 64'h22);
    chk("R9 address written", rd_addr_o, 64'hC0);
    chk("R9 global status installed", gstat_o, 64'h5);
  endtask

  task automatic t_drop;
    inject(8'd1, VAL | 64'h44, 64'd0, 64'hE0, 64'hE1, 1'b0);
    outcome("R5 dropped while in progress", 1'b0, 1'b0, 1'b0, 3'd0);
    rd(1);
    chk("R5 dropped leaves bank empty", rd_status_o, 64'd0);
    chk("R5 dropped leaves global status", gstat_o, 64'h5);
    inject(8'd1, VAL | 64'h44, 64'd0, 64'hE0, 64'hE1, 1'b1);
    rd(1);
    chk("R5 unconditional flag processes", rd_status_o, VAL | 64'h44);
  endtask

  task automatic t_ce_over_uc;
    load(3'd2, '0, 64'd0);
    load(3'd4, 3'd2, VAL | UC | 64'h33);
    load(3'd5, 3'd2, 64'hAA);
    inject(8'd2, VAL | 64'h77, 64'd0, 64'hBB, 64'hCC, 1'b0);
    outcome("R11 no exception for corrected", 1'b0, 1'b0, 1'b0, 3'd0);
    rd(2);
    chk("R11 only overflow marked", rd_status_o, VAL | UC | OVF | 64'h33);
    chk("R11 address kept", rd_addr_o, 64'hAA);
  endtask

  task automatic t_shutdown;
    load(3'd2, '0, 64'h4);
    inject(8'd3, VAL | UC | AR | 64'h55, 64'h0, 64'h1, 64'h1, 1'b0);
    outcome("R8 in progress escalates", 1'b0, 1'b1, 1'b0, 3'd0);
    rd(3);
    chk("R8 bank unchanged", rd_status_o, VAL | 64'h13);
    load(3'd2, '0, 64'h0);
    mce_en = 1'b0;
    inject(8'd3, VAL | UC | 64'h56, 64'h0, 64'h1, 64'h1, 1'b0);
    outcome("R8 machine-check disabled escalates", 1'b0, 1'b1, 1'b0, 3'd0);
    mce_en = 1'b1;
  endtask

  task automatic t_gctl;
    load(3'd1, '0, ~64'h1);
    inject(8'd3, VAL | UC | 64'h66, 64'h0, 64'h3A, 64'h3B, 1'b0);
    outcome("R6 global mask not all ones", 1'b0, 1'b0, 1'b1, 3'd4);
    load(3'd0, '0, 64'h004);
    inject(8'd3, VAL | UC | 64'h66, 64'h0, 64'h3A, 64'h3B, 1'b0);
    outcome("R6 mask ignored without capability flag", 1'b1, 1'b0, 1'b0, 3'd0);
    rd(3);
    chk("R6 logged with overflow", rd_status_o, VAL | UC | OVF | 64'h66);
    load(3'd0, '0, 64'h104);
    load(3'd1, '0, ONES);
  endtask

  task automatic t_bankctl;
    load(3'd3, 3'd1, 64'd0);
    inject(8'd1, VAL | UC | 64'h88, 64'h0, 64'h9, 64'h9, 1'b0);
    outcome("R7 bank mask not all ones", 1'b0, 1'b0, 1'b1, 3'd5);
    rd(1);
    chk("R7 bank unchanged", rd_status_o, VAL | 64'h44);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_nocap;
    t_setup;
    t_badbank;
    t_invalid;
    t_ce;
    t_uc_over_ce;
    t_drop;
    t_ce_over_uc;
    t_shutdown;
    t_gctl;
    t_bankctl;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule